// File: doc/BRIEF.md
# Fast PWM Timer with Selectable Period Source

This block is a 16-bit up-counting timer that runs only in fast PWM operation. Each enabled tick moves the counter from zero towards a period limit, and the counter returns to zero on the tick after it reaches that limit. A 4-bit mode field sets where the limit comes from. It is either a dedicated period register or the active value of compare channel A. A small write port loads the mode, the period register and the two compare buffers.

Compare values written by software wait in a buffer. While a PWM mode is running, they reach the active compare registers only on the tick where the counter sits at the period limit, so a duty-cycle change never splits a period. Channel B, and channel A when the period register sets the limit, give non-inverting PWM. When channel A itself sets the limit, output A toggles once per period and gives a 50% square wave. Sticky flags mark the period limit, each compare match and capture events. Capture events are ignored while the period register sets the limit.

Top module: `fast_pwm_timer`

## Requirements
- R1: After reset the counter is 0, both PWM outputs are low, all four flags are clear and the mode is 0, so the timer does not count.
- R2: The counter changes only on a clock edge where tickEn is high and the mode is 14 or 15. On such a tick it goes up by one, or goes to 0 when it equals the period limit.
- R3: In mode 14 the period limit is the period register. In mode 15 it is the active compare A value.
- R4: With any mode other than 14 or 15 (13 included) the counter holds, and writes to the compare buffers reach the active compare registers on the next cycle.
- R5: In modes 14 and 15 the active compare registers take the buffered values only on the tick where the counter equals the period limit.
- R6: The overflow flag (flags bit 0) is set by the tick on which the counter equals the period limit.
- R7: Flag bit 1 (match A) and flag bit 2 (match B) are set by a tick on which the counter equals the active compare A or B value.
- R8: Output pwmB, and output pwmA in mode 14, goes high on the wrapping tick and goes low on the tick after the counter equals its active compare value. Per period it is high for min(compare, limit)+1 counts.
- R9: In mode 15, pwmA inverts on every wrapping tick.
- R10: A capEvt pulse copies the counter into the period register and sets flag bit 3, except in mode 14, where the pulse has no effect.
- R11: Flags stay set until the matching clrFlags bit is high for a cycle. A set in the same cycle as a clear wins.
- R12: Write addresses: 0 is the mode (wrData[3:0]), 1 is the period register, 2 is the compare A buffer, 3 is the compare B buffer. The period register is visible on periodVal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable, one tick per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | 16 | Write data |
| capEvt | input | 1 | Capture event pulse |
| clrFlags | input | 4 | Write-one-to-clear strobes for the flags |
| count | output | 16 | Counter value |
| periodVal | output | 16 | Period/capture register |
| pwmA | output | 1 | Channel A waveform |
| pwmB | output | 1 | Channel B waveform |
| flags | output | 4 | {capture, matchB, matchA, overflow} |

## Verification
The bench sweeps compare B below, at and above the period limit, and includes a compare of zero. A design with an off-by-one match would give the wrong high time, and one that let the match override the wrap would never hold the output high. It writes a new compare value in the middle of a period, in both modes. A design without buffering would then change the duty or the wrap point at once, where the correct design waits until the next period. It also checks that mode 13 does not count, that a capture in mode 14 leaves the period register alone, and that clearing one flag leaves the others set.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic run;
    logic wrap;
    logic load;
    logic hitA;
    logic hitB;
    logic capture;
    logic aIsTop;
  } ctlStrobes_t;

  localparam logic [3:0] MODE_PERIOD_TOP = 4'd14;
  localparam logic [3:0] MODE_CMPA_TOP   = 4'd15;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_PERIOD = 2'd1;
  localparam logic [1:0] ADDR_CMPA   = 2'd2;
  localparam logic [1:0] ADDR_CMPB   = 2'd3;

  localparam int FLAG_OVF = 0;
  localparam int FLAG_MA  = 1;
  localparam int FLAG_MB  = 2;
  localparam int FLAG_CAP = 3;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         capEvt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] periodReg,
  input  logic [W-1:0] actA,
  input  logic [W-1:0] actB,
  output ctlStrobes_t  strobes
);
  logic [3:0]   modeReg;
  logic         pwmMode;
  logic [W-1:0] topVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= '0;
    else if (wrEn && wrAddr == ADDR_MODE) modeReg <= wrData[3:0];
  end

  always_comb begin
    pwmMode         = (modeReg == MODE_PERIOD_TOP) || (modeReg == MODE_CMPA_TOP);
    strobes.aIsTop  = (modeReg == MODE_CMPA_TOP);
    topVal          = strobes.aIsTop ? actA : periodReg;
    strobes.run     = tickEn && pwmMode;
    strobes.wrap    = strobes.run && (cnt == topVal);
    strobes.load    = strobes.wrap || !pwmMode;
    strobes.hitA    = strobes.run && (cnt == actA);
    strobes.hitB    = strobes.run && (cnt == actB);
    strobes.capture = capEvt && (modeReg != MODE_PERIOD_TOP);
  end

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (cnt == '0));

  // R12
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_MODE) |=> (strobes.aIsTop == ($past(wrData[3:0]) == MODE_CMPA_TOP)));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int W = 16,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [W-1:0]  wrData,
  input  logic [NF-1:0] clrFlags,
  input  ctlStrobes_t   strobes,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  periodReg,
  output logic [W-1:0]  actA,
  output logic [W-1:0]  actB,
  output logic          pwmA,
  output logic          pwmB,
  output logic [NF-1:0] flags
);
  logic [W-1:0]  bufA, bufB;
  logic [NF-1:0] setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobes.run) cnt <= strobes.wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufA <= '0;
      bufB <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CMPA) bufA <= wrData;
      if (wrAddr == ADDR_CMPB) bufB <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actA <= '0;
      actB <= '0;
    end else if (strobes.load) begin
      actA <= bufA;
      actB <= bufB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periodReg <= '0;
    else if (wrEn && wrAddr == ADDR_PERIOD) periodReg <= wrData;
    else if (strobes.capture) periodReg <= cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmB <= 1'b0;
    else if (strobes.wrap) pwmB <= 1'b1;
    else if (strobes.hitB) pwmB <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmA <= 1'b0;
    else if (strobes.wrap) pwmA <= strobes.aIsTop ? ~pwmA : 1'b1;
    else if (strobes.hitA && !strobes.aIsTop) pwmA <= 1'b0;
  end

  always_comb begin
    setVec           = '0;
    setVec[FLAG_OVF] = strobes.wrap;
    setVec[FLAG_MA]  = strobes.hitA;
    setVec[FLAG_MB]  = strobes.hitB;
    setVec[FLAG_CAP] = strobes.capture;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else if (setVec[i]) flags[i] <= 1'b1;
      else if (clrFlags[i]) flags[i] <= 1'b0;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |=> $stable(cnt));

  // R5
  act_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(actA) && $stable(actB)));

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> flags[FLAG_OVF]);

  // R9
  pwma_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrap && strobes.aIsTop) |=> (pwmA != $past(pwmA)));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLAG_OVF] && !clrFlags[FLAG_OVF]) |=> flags[FLAG_OVF]);
endmodule

// File: rtl/fast_pwm_timer.sv
module fast_pwm_timer
  import pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         capEvt,
  input  logic [3:0]   clrFlags,
  output logic [W-1:0] count,
  output logic [W-1:0] periodVal,
  output logic         pwmA,
  output logic         pwmB,
  output logic [3:0]   flags
);
  ctlStrobes_t  strobes;
  logic [W-1:0] actA, actB;

  pwm_ctrl #(.W(W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .capEvt(capEvt), .cnt(count), .periodReg(periodVal),
    .actA(actA), .actB(actB), .strobes(strobes)
  );

  pwm_datapath #(.W(W), .NF(4)) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrFlags(clrFlags), .strobes(strobes), .cnt(count), .periodReg(periodVal),
    .actA(actA), .actB(actB), .pwmA(pwmA), .pwmB(pwmB), .flags(flags)
  );
endmodule

// File: tb/sim_fast_pwm_timer.sv
`timescale 1ns/1ps
module sim_fast_pwm_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        capEvt = 1'b0;
  logic [3:0]  clrFlags = '0;
  logic [15:0] count, periodVal;
  logic        pwmA, pwmB;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fast_pwm_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .capEvt(capEvt), .clrFlags(clrFlags), .count(count),
    .periodVal(periodVal), .pwmA(pwmA), .pwmB(pwmB), .flags(flags)
  );

  // {period, compare B, expected high counts per period}
  localparam int VEC[6][3] = '{
    '{9, 3, 4}, '{9, 0, 1}, '{9, 9, 10}, '{9, 20, 10}, '{4, 2, 3}, '{15, 7, 8}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic writeReg(logic [1:0] a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickEn = 1'b1;
      @(negedge clk) tickEn = 1'b0;
    end
  endtask

  task automatic pulseCap();
    @(negedge clk) capEvt = 1'b1;
    @(negedge clk) capEvt = 1'b0;
  endtask

  task automatic pulseClr(logic [3:0] m);
    @(negedge clk) clrFlags = m;
    @(negedge clk) clrFlags = '0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 count", count, 0);
    check("R1 pwm", {pwmA, pwmB}, 0);
    check("R1 flags", flags, 0);

    // R8 R6 duty sweep in mode 14
    for (int v = 0; v < 6; v++) begin
      int hi;
      doReset();
      writeReg(2'd1, VEC[v][0]);
      writeReg(2'd3, VEC[v][1]);
      writeReg(2'd0, 14);
      ticks(VEC[v][0] + 1);
      hi = 0;
      for (int k = 0; k <= VEC[v][0]; k++) begin
        if (pwmB) hi++;
        ticks(1);
      end
      check("R8 high counts", hi, VEC[v][2]);
      check("R6 ovf flag", flags[0], 1);
    end

    // R4 R12 reserved mode does not count
    doReset();
    writeReg(2'd0, 13);
    writeReg(2'd1, 9);
    ticks(4);
    check("R4 mode13 count", count, 0);
    check("R12 period write", periodVal, 9);

    // R2 R7 R10 mode 14
    writeReg(2'd2, 2);
    writeReg(2'd3, 3);
    writeReg(2'd0, 14);
    ticks(3);
    check("R2 count after 3 ticks", count, 3);
    check("R7 matchA flag", flags[1], 1);
    check("R7 matchB not yet", flags[2], 0);
    repeat (5) @(negedge clk);
    check("R2 hold without tick", count, 3);
    pulseCap();
    check("R10 capture ignored value", periodVal, 9);
    check("R10 capture ignored flag", flags[3], 0);

    // R5 R3 buffered compare B
    writeReg(2'd3, 7);
    ticks(7);
    check("R3 wrap at period", count, 0);
    check("R6 ovf after wrap", flags[0], 1);
    writeReg(2'd3, 1);
    ticks(5);
    check("R5 old compare kept", pwmB, 1);
    pulseClr(4'b0001);
    check("R11 ovf cleared", flags[0], 0);
    check("R11 matchB sticky", flags[2], 1);

    // R9 R3 R10 R5 mode 15
    doReset();
    writeReg(2'd2, 4);
    writeReg(2'd0, 15);
    ticks(5);
    check("R3 wrap at compare A", count, 0);
    check("R9 pwmA toggled high", pwmA, 1);
    ticks(2);
    pulseCap();
    check("R10 capture value", periodVal, 2);
    check("R10 capture flag", flags[3], 1);
    writeReg(2'd2, 6);
    ticks(3);
    check("R5 old top kept", count, 0);
    check("R9 pwmA toggled low", pwmA, 0);
    ticks(6);
    check("R3 new top count", count, 6);
    ticks(1);
    check("R3 new top wrap", count, 0);

    finishRun();
  end
endmodule